// File: doc/BRIEF.md
# LIN Frame Sequencer with Abort and Status Flags

This block sequences the frame phases of a LIN node, in either the master or the slave role, above a byte-level UART and a break/sync detector. Software starts a phase by writing a 2-bit command: send a header, receive a response or transmit a response. The block tracks the active phase. It counts response bytes from the UART's byte-done strobes and reports completion through sticky flags.

On a slave, a break/sync sequence can arrive while a response is still in progress, even partway through a byte. The block then drops the response at once and starts header reception. A received response that is cut off this way raises a frame error. A transmitted response that is cut off raises a bit error. A master never drops a response on its own. Software must write the abort command, which returns the block to idle and raises an abort error, and then issue a new header command. Four sticky flags feed two interrupt lines: completion (receive and transmit) and status (identifier and error). Each flag has its own enable bit.

Top module: `linFrameSeq`

## Requirements
- R1: While reset is held and right after it, phase is 0 (idle), busy is 0, flags is 0, the three error detail outputs are 0 and both interrupt lines are 0.
- R2: The command field is encoded 00 = abort, 01 = send header, 10 = receive response, 11 = transmit response. From idle, command 01 moves phase to 1 (header), but only when isMaster is 1. Command 10 moves phase to 2 (rx). Command 11 moves phase to 3 (tx). Busy is 1 exactly when phase is not 0. Commands other than abort are ignored while busy, and a slave ignores command 01.
- R3: In the header phase, an idDone strobe sets flags bit 2 (identifier received) and returns phase to idle on the same clock edge.
- R4: A response phase completes on the respLen-th byte strobe of its direction (rxByte for rx, txByte for tx). A respLen of 0 counts as 1. Completion sets flags bit 0 (rx) or bit 1 (tx) and returns to idle. Earlier strobes leave the phase unchanged.
- R5: Byte strobes have no effect on phase or flags while idle or in the header phase, including just after an abort.
- R6: On a slave (isMaster = 0), breakSync moves phase to 1 on the next edge from any phase. In rx it also sets errFrame and flags bit 3. In tx it also sets errBit and flags bit 3. A break wins over a byte strobe, idDone or a command in the same cycle.
- R7: On a master, breakSync has no effect on phase or flags.
- R8: Command 00 while busy returns phase to 0 on the next edge and sets errAbort and flags bit 3. Command 00 while idle changes nothing.
- R9: Flags and error details are sticky until cleared. Writing 1 to flagClr bit i clears flags bit i, and flagClr bit 3 also clears the three detail outputs. A set in the same cycle wins over a clear.
- R10: irqDone = (flags[0] & irqEn[0]) | (flags[1] & irqEn[1]) and irqStatus = (flags[2] & irqEn[2]) | (flags[3] & irqEn[3]), with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | Node role: 1 master, 0 slave |
| cmdWr | input | 1 | Command write strobe |
| cmd | input | 2 | Command code |
| respLen | input | CNT_W | Response length in bytes, data plus checksum |
| breakSync | input | 1 | Break/sync sequence recognised strobe |
| idDone | input | 1 | Protected identifier received strobe |
| rxByte | input | 1 | UART received-byte strobe |
| txByte | input | 1 | UART transmitted-byte strobe |
| flagClr | input | 4 | Write-1-to-clear mask for the flags |
| irqEn | input | 4 | Per-flag interrupt enables |
| phase | output | 2 | Current frame phase |
| busy | output | 1 | A phase is in progress |
| flags | output | 4 | {error, identifier, tx done, rx done} |
| errBit | output | 1 | Bit error from a slave tx response cut by a break |
| errFrame | output | 1 | Frame error from a slave rx response cut by a break |
| errAbort | output | 1 | Frame aborted by command |
| irqDone | output | 1 | Completion interrupt |
| irqStatus | output | 1 | Identifier/error interrupt |

## Verification
The bench builds the block with CNT_W = 3. That puts every response length from 0 to 7 within reach, in both directions. With a 5-byte response, a slave break is placed at every byte position, with a byte strobe arriving in the same cycle. All 16 flag patterns are combined with all 16 enable masks, which sweeps the interrupt combine exhaustively.

// File: rtl/linseq_pkg.sv
package linseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_RX   = 2'd2,
    PH_TX   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CMD_ABORT = 2'd0,
    CMD_HDR   = 2'd1,
    CMD_RX    = 2'd2,
    CMD_TX    = 2'd3
  } cmd_e;

  localparam int NFLAG = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setRx;
    logic setTx;
    logic setId;
    logic setBit;
    logic setFrm;
    logic setAbort;
  } strobe_t;

endpackage

// File: rtl/linSeqCtrl.sv
module linSeqCtrl
  import linseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic       cmdWr,
  input  logic [1:0] cmd,
  input  logic       breakSync,
  input  logic       idDone,
  input  logic       rxByte,
  input  logic       txByte,
  input  logic       cntLast,
  output phase_e     phase,
  output strobe_t    stb
);

  phase_e phaseNxt;
  logic   slaveBreak;
  logic   abortCmd;

  assign slaveBreak = !isMaster && breakSync;
  assign abortCmd   = cmdWr && (cmd == CMD_ABORT);

  always_comb begin
    phaseNxt = phase;
    stb      = '0;
    if (slaveBreak) begin
      // break pre-empts everything, even a byte in flight
      phaseNxt = PH_HDR;
      if (phase == PH_RX) stb.setFrm = 1'b1;
      if (phase == PH_TX) stb.setBit = 1'b1;
    end else if (abortCmd) begin
      if (phase != PH_IDLE) begin
        phaseNxt     = PH_IDLE;
        stb.setAbort = 1'b1;
      end
    end else begin
      case (phase)
        PH_IDLE: begin
          if (cmdWr) begin
            case (cmd)
              CMD_HDR: if (isMaster) phaseNxt = PH_HDR;
              CMD_RX: begin
                phaseNxt    = PH_RX;
                stb.loadCnt = 1'b1;
              end
              CMD_TX: begin
                phaseNxt    = PH_TX;
                stb.loadCnt = 1'b1;
              end
              default: ;
            endcase
          end
        end
        PH_HDR: begin
          if (idDone) begin
            stb.setId = 1'b1;
            phaseNxt  = PH_IDLE;
          end
        end
        PH_RX: begin
          if (rxByte) begin
            if (cntLast) begin
              stb.setRx = 1'b1;
              phaseNxt  = PH_IDLE;
            end else begin
              stb.decCnt = 1'b1;
            end
          end
        end
        PH_TX: begin
          if (txByte) begin
            if (cntLast) begin
              stb.setTx = 1'b1;
              phaseNxt  = PH_IDLE;
            end else begin
              stb.decCnt = 1'b1;
            end
          end
        end
        default: phaseNxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  // R6: slave break always lands in header phase
  a_r6_break_to_header: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && breakSync) |=> (phase == PH_HDR));

  // R8: abort while busy returns to idle within one clock
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmd == 2'b00 && phase != PH_IDLE && !(!isMaster && breakSync))
      |=> (phase == PH_IDLE));

  // R7: master ignores break when nothing else happens
  a_r7_master_break: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && breakSync && !cmdWr && !idDone && !rxByte && !txByte)
      |=> $stable(phase));

  // R5: idle stays idle without a command or slave break
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !cmdWr && !(!isMaster && breakSync))
      |=> (phase == PH_IDLE));

endmodule

// File: rtl/linSeqFlags.sv
module linSeqFlags
  import linseq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] respLen,
  input  logic [NFLAG-1:0] flagClr,
  input  logic [NFLAG-1:0] irqEn,
  input  strobe_t          stb,
  output logic             cntLast,
  output logic [NFLAG-1:0] flags,
  output logic             errBit,
  output logic             errFrame,
  output logic             errAbort,
  output logic             irqDone,
  output logic             irqStatus
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] byteCnt;
  logic [NFLAG-1:0] setVec;
  logic             anyErr;

  // remaining-byte counter; 0 or 1 both mean last byte
  always_ff @(posedge clk) begin
    if (!rstN)           byteCnt <= '0;
    else if (stb.loadCnt) byteCnt <= respLen;
    else if (stb.decCnt)  byteCnt <= byteCnt - CNT_ONE;
  end
  assign cntLast = (byteCnt <= CNT_ONE);

  assign anyErr = stb.setBit | stb.setFrm | stb.setAbort;
  assign setVec = {anyErr, stb.setId, stb.setTx, stb.setRx};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= setVec[i] | (flags[i] & ~flagClr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errBit   <= 1'b0;
      errFrame <= 1'b0;
      errAbort <= 1'b0;
    end else begin
      errBit   <= stb.setBit   | (errBit   & ~flagClr[3]);
      errFrame <= stb.setFrm   | (errFrame & ~flagClr[3]);
      errAbort <= stb.setAbort | (errAbort & ~flagClr[3]);
    end
  end

  assign irqDone   = (flags[0] & irqEn[0]) | (flags[1] & irqEn[1]);
  assign irqStatus = (flags[2] & irqEn[2]) | (flags[3] & irqEn[3]);

  // R9: a flag stays set until its clear bit is written
  a_r9_sticky_rx: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !flagClr[0]) |=> flags[0]);

  // R9: set wins over a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    stb.setRx |=> flags[0]);

  // R6: frame error from a slave break in rx
  a_r6_frame_err: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFrm |=> (errFrame && flags[3]));

  // R8: abort raises its detail and the error flag
  a_r8_abort_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.setAbort |=> (errAbort && flags[3]));

endmodule

// File: rtl/linFrameSeq.sv
module linFrameSeq
  import linseq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             cmdWr,
  input  logic [1:0]       cmd,
  input  logic [CNT_W-1:0] respLen,
  input  logic             breakSync,
  input  logic             idDone,
  input  logic             rxByte,
  input  logic             txByte,
  input  logic [3:0]       flagClr,
  input  logic [3:0]       irqEn,
  output logic [1:0]       phase,
  output logic             busy,
  output logic [3:0]       flags,
  output logic             errBit,
  output logic             errFrame,
  output logic             errAbort,
  output logic             irqDone,
  output logic             irqStatus
);

  phase_e  ctrlPhase;
  strobe_t stb;
  logic    cntLast;

  linSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .isMaster  (isMaster),
    .cmdWr     (cmdWr),
    .cmd       (cmd),
    .breakSync (breakSync),
    .idDone    (idDone),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .cntLast   (cntLast),
    .phase     (ctrlPhase),
    .stb       (stb)
  );

  linSeqFlags #(.CNT_W(CNT_W)) uFlags (
    .clk       (clk),
    .rstN      (rstN),
    .respLen   (respLen),
    .flagClr   (flagClr),
    .irqEn     (irqEn),
    .stb       (stb),
    .cntLast   (cntLast),
    .flags     (flags),
    .errBit    (errBit),
    .errFrame  (errFrame),
    .errAbort  (errAbort),
    .irqDone   (irqDone),
    .irqStatus (irqStatus)
  );

  assign phase = ctrlPhase;
  assign busy  = (ctrlPhase != PH_IDLE);

endmodule

// File: tb/tb_linFrameSeq.sv
`timescale 1ns/100ps
module tb_linFrameSeq;

  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          isMaster = 1'b1;
  logic          cmdWr = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [CW-1:0] respLen = '0;
  logic          breakSync = 1'b0;
  logic          idDone = 1'b0;
  logic          rxByte = 1'b0;
  logic          txByte = 1'b0;
  logic [3:0]    flagClr = 4'h0;
  logic [3:0]    irqEn = 4'h0;
  logic [1:0]    phase;
  logic          busy;
  logic [3:0]    flags;
  logic          errBit, errFrame, errAbort, irqDone, irqStatus;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  linFrameSeq #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cmdWr(cmdWr), .cmd(cmd),
    .respLen(respLen), .breakSync(breakSync), .idDone(idDone),
    .rxByte(rxByte), .txByte(txByte), .flagClr(flagClr), .irqEn(irqEn),
    .phase(phase), .busy(busy), .flags(flags), .errBit(errBit),
    .errFrame(errFrame), .errAbort(errAbort), .irqDone(irqDone),
    .irqStatus(irqStatus)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c);
    cmdWr = 1'b1; cmd = c; step(); cmdWr = 1'b0;
  endtask

  task automatic clearAll();
    flagClr = 4'hF; step(); flagClr = 4'h0;
  endtask

  task automatic pulseRx(); rxByte = 1'b1; step(); rxByte = 1'b0; endtask
  task automatic pulseTx(); txByte = 1'b1; step(); txByte = 1'b0; endtask
  task automatic pulseId(); idDone = 1'b1; step(); idDone = 1'b0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 phase", phase, 0);
    chk("R1 busy", busy, 0);
    chk("R1 flags", flags, 0);
    chk("R1 details", {errBit, errFrame, errAbort}, 0);
    chk("R1 irqs", {irqDone, irqStatus}, 0);
    rstN = 1'b1; step();
    chk("R1 after release", {phase, flags}, 0);

    // R2/R3/R5 master header
    isMaster = 1'b1;
    issue(2'b01);
    chk("R2 header phase", phase, 1);
    chk("R2 busy", busy, 1);
    pulseRx();
    chk("R5 byte in header", phase, 1);
    chk("R5 flags in header", flags, 0);
    issue(2'b10);
    chk("R2 cmd ignored while busy", phase, 1);
    pulseId();
    chk("R3 idle after id", phase, 0);
    chk("R3 id flag", flags, 4);
    chk("R2 busy low", busy, 0);

    // R2 slave cannot send header
    isMaster = 1'b0; clearAll();
    issue(2'b01);
    chk("R2 slave header ignored", phase, 0);

    // R4/R5 length sweep, both directions
    isMaster = 1'b1;
    for (int dir = 0; dir < 2; dir++) begin
      for (int len = 0; len < 8; len++) begin
        int n;
        n = (len == 0) ? 1 : len;
        clearAll();
        respLen = CW'(len);
        issue(dir == 0 ? 2'b10 : 2'b11);
        chk("R2 response phase", phase, dir == 0 ? 2 : 3);
        for (int k = 1; k < n; k++) begin
          if (dir == 0) pulseRx(); else pulseTx();
          chk("R4 not yet done", {busy, phase}, dir == 0 ? 6 : 7);
        end
        if (dir == 0) pulseRx(); else pulseTx();
        chk("R4 done idle", phase, 0);
        chk("R4 done flag", flags, dir == 0 ? 1 : 2);
        pulseRx(); pulseTx();
        chk("R5 idle bytes ignored", {phase, flags}, dir == 0 ? 1 : 2);
      end
    end

    // R6 slave break at every byte position, with a same-cycle byte
    isMaster = 1'b0;
    for (int dir = 0; dir < 2; dir++) begin
      for (int pos = 0; pos < 5; pos++) begin
        clearAll();
        respLen = CW'(5);
        issue(dir == 0 ? 2'b10 : 2'b11);
        for (int k = 0; k < pos; k++) begin
          if (dir == 0) pulseRx(); else pulseTx();
        end
        breakSync = 1'b1;
        if (dir == 0) rxByte = 1'b1; else txByte = 1'b1;
        step();
        breakSync = 1'b0; rxByte = 1'b0; txByte = 1'b0;
        chk("R6 break to header", phase, 1);
        chk("R6 error flag only", flags, 8);
        chk("R6 role detail", {errBit, errFrame}, dir == 0 ? 1 : 2);
        pulseId();
        chk("R6 new frame id", {phase, flags}, 12);
      end
    end
    // R6 break beats command
    clearAll();
    breakSync = 1'b1; cmdWr = 1'b1; cmd = 2'b10; step();
    breakSync = 1'b0; cmdWr = 1'b0;
    chk("R6 break beats command", phase, 1);
    pulseId();

    // R7 master ignores break
    isMaster = 1'b1; clearAll();
    respLen = CW'(3);
    issue(2'b10);
    breakSync = 1'b1; step(); breakSync = 1'b0;
    chk("R7 master break phase", phase, 2);
    chk("R7 master break flags", flags, 0);
    pulseRx(); pulseRx(); pulseRx();
    chk("R7 frame still completes", {phase, flags}, 1);

    // R8 abort then restart with header
    clearAll();
    issue(2'b10); pulseRx();
    issue(2'b00);
    chk("R8 abort idle", phase, 0);
    chk("R8 abort flags", flags, 8);
    chk("R8 abort detail", {errBit, errFrame, errAbort}, 1);
    pulseRx();
    chk("R5 byte after abort", {phase, flags}, 8);
    issue(2'b01);
    chk("R8 header after abort", phase, 1);
    pulseId();
    clearAll();
    chk("R9 clear error details", {errBit, errFrame, errAbort, flags}, 0);
    issue(2'b00);
    chk("R8 idle abort no effect", {errAbort, flags, phase}, 0);

    // R9 sticky, set beats clear
    respLen = CW'(1);
    issue(2'b10); pulseRx();
    step(); step(); step();
    chk("R9 sticky", flags, 1);
    flagClr = 4'h2; step(); flagClr = 4'h0;
    chk("R9 other clear bit", flags, 1);
    flagClr = 4'h1; step(); flagClr = 4'h0;
    chk("R9 cleared", flags, 0);
    issue(2'b10);
    rxByte = 1'b1; flagClr = 4'h1; step(); rxByte = 1'b0; flagClr = 4'h0;
    chk("R9 set beats clear", flags, 1);

    // R10 all flag patterns x all enable masks
    for (int p = 0; p < 16; p++) begin
      clearAll();
      respLen = CW'(1);
      if (p[0]) begin issue(2'b10); pulseRx(); end
      if (p[1]) begin issue(2'b11); pulseTx(); end
      if (p[2]) begin issue(2'b01); pulseId(); end
      if (p[3]) begin issue(2'b10); issue(2'b00); end
      chk("R9 flag pattern", flags, p);
      for (int e = 0; e < 16; e++) begin
        irqEn = 4'(e);
        #1;
        chk("R10 irqDone", irqDone, (p[0] & e[0]) | (p[1] & e[1]));
        chk("R10 irqStatus", irqStatus, (p[2] & e[2]) | (p[3] & e[3]));
      end
      irqEn = 4'h0;
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule